// File: doc/BRIEF.md
# Local interrupt priority and acknowledge unit

This block is the pending/in-service core of a per-processor interrupt controller. It keeps three one-bit-per-vector maps over the full vector space: pending requests, vectors in service, and the trigger mode each pending vector arrived with. It also holds a task-priority value and a spurious/enable register. Interrupt sources post a vector number together with a level/edge flag. The unit derives a processor priority from the task priority and the highest vector in service. It raises its interrupt line while the best pending request belongs to a higher priority class than that processor priority.

The processor talks to the block through two single-cycle strobes. An acknowledge strobe takes the highest pending vector into service and returns it. If the task priority forbids that vector, the strobe returns the spurious vector and changes nothing. An end-of-interrupt strobe retires the highest vector in service. A query port reads the three per-vector bits of any chosen vector, which lets the map state be inspected without a wide bus.

Top module: `intr_prio_unit`

## Requirements
- R1: The vector returned by an accepted acknowledge is the highest-numbered pending vector; with several pending, repeated acknowledges return them in descending order.
- R2: A request on `reqVector` sets that vector's pending bit on the next clock edge. The same edge sets its trigger bit when `reqLevel`=1 (level) and clears it when `reqLevel`=0 (edge).
- R3: `pprOut` equals `tprOut` when no vector is in service, or when the in-service class (bits 7:4) of the highest in-service vector is not greater than bits 7:4 of `tprOut`. Otherwise it equals that vector's bits 7:4 with bits 3:0 zero.
- R4: `intOut` is 1 only when `svrOut[8]`=1 and a vector is pending. It is 0 when `pprOut` is non-zero and bits 7:4 of the highest pending vector are not greater than bits 7:4 of `pprOut`.
- R5: An acknowledge is refused when `svrOut[8]`=0, when nothing is pending, or when `tprOut` is non-zero and the highest pending vector is less than or equal to `tprOut`. A refused acknowledge returns `svrOut[7:0]` on `ackVector` and leaves every map unchanged.
- R6: An accepted acknowledge clears the returned vector's pending bit and sets its in-service bit on the clock edge that ends the strobe.
- R7: End-of-interrupt clears only the highest set in-service bit; with nothing in service it changes no map.
- R8: After reset `svrOut`=0x0FF, `tprOut`=0, `pprOut`=0, `intOut`=0, and every pending, in-service and trigger bit reads 0.
- R9: A spurious-register write stores only bits 8:0 of `svrWrData`; a task-priority write stores all 8 bits of `tprWrData`.
- R10: When a request and an accepted acknowledge for the same vector fall in one cycle, the vector ends up both pending and in service. When an acknowledge and an end-of-interrupt fall in one cycle, the end-of-interrupt retires the previous highest in-service vector and the acknowledged vector remains in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Post a request this cycle |
| reqVector | input | 8 | Requested vector number |
| reqLevel | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ackStrobe | input | 1 | Acknowledge strobe |
| ackVector | output | 8 | Vector an acknowledge returns in the current cycle |
| eoiStrobe | input | 1 | End-of-interrupt strobe |
| tprWrEn | input | 1 | Task-priority write enable |
| tprWrData | input | 8 | Task-priority write value |
| svrWrEn | input | 1 | Spurious/enable register write enable |
| svrWrData | input | 16 | Spurious/enable write value (bits 8:0 kept) |
| queryVector | input | 8 | Vector whose map bits are read |
| queryPending | output | 1 | Pending bit of `queryVector` |
| queryInService | output | 1 | In-service bit of `queryVector` |
| queryLevel | output | 1 | Trigger bit of `queryVector` |
| intOut | output | 1 | Interrupt line to the processor |
| pprOut | output | 8 | Processor priority |
| tprOut | output | 8 | Task priority |
| svrOut | output | 9 | Spurious vector (7:0) and enable (8) |

## Verification
Two pairs of functions can land in one cycle. The first is an acknowledge together with a new request for the very vector being taken. The second is an acknowledge together with an end-of-interrupt. The bench drives both strobes in the same cycle from a state it has set up in advance. It then reads the pending and in-service bits of the vectors involved through the query port. The expected values are the order the requirements fix: the request lands after the acknowledge has cleared the bit, and the retirement acts on the in-service map as it stood before the acknowledge.

// File: rtl/intr_prio_pkg.sv
package intr_prio_pkg;

  typedef struct packed {
    logic reqSet;
    logic reqLevel;
    logic ackTake;
    logic eoiClear;
  } ctrlStrobes_t;

endpackage

// File: rtl/prio_find.sv
module prio_find #(
  parameter int N = 256,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = i[IDX_W-1:0];
      end
    end
  end

endmodule

// File: rtl/intr_vec_dp.sv
module intr_vec_dp
  import intr_prio_pkg::*;
#(
  parameter int VEC_W = 8,
  localparam int NUM_VEC = 1 << VEC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [VEC_W-1:0] reqVector,
  input  logic [VEC_W-1:0] queryVector,
  output logic             irrFound,
  output logic [VEC_W-1:0] irrIdx,
  output logic             isrFound,
  output logic [VEC_W-1:0] isrIdx,
  output logic             queryPending,
  output logic             queryInService,
  output logic             queryLevel
);

  logic [NUM_VEC-1:0] irrQ, isrQ, tmrQ;
  logic [NUM_VEC-1:0] irrN, isrN, tmrN;

  prio_find #(.N(NUM_VEC)) uIrrFind (.vec(irrQ), .found(irrFound), .idx(irrIdx));
  prio_find #(.N(NUM_VEC)) uIsrFind (.vec(isrQ), .found(isrFound), .idx(isrIdx));

  // Clear-then-set ordering: a request lands after an acknowledge clear,
  // an acknowledge set lands after an end-of-interrupt clear.
  always_comb begin
    irrN = irrQ;
    isrN = isrQ;
    tmrN = tmrQ;
    if (strobes.ackTake) irrN[irrIdx] = 1'b0;
    if (strobes.reqSet) begin
      irrN[reqVector] = 1'b1;
      tmrN[reqVector] = strobes.reqLevel;
    end
    if (strobes.eoiClear && isrFound) isrN[isrIdx] = 1'b0;
    if (strobes.ackTake) isrN[irrIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irrQ <= '0;
      isrQ <= '0;
      tmrQ <= '0;
    end else begin
      irrQ <= irrN;
      isrQ <= isrN;
      tmrQ <= tmrN;
    end
  end

  assign queryPending   = irrQ[queryVector];
  assign queryInService = isrQ[queryVector];
  assign queryLevel     = tmrQ[queryVector];

  assert_req_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reqSet |=> irrQ[$past(reqVector)] && (tmrQ[$past(reqVector)] == $past(strobes.reqLevel)));

  assert_ack_to_service_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ackTake |=> isrQ[$past(irrIdx)]);

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ackTake && !(strobes.reqSet && reqVector == irrIdx)) |=> !irrQ[$past(irrIdx)]);

  assert_eoi_retires_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.eoiClear && isrFound && !strobes.ackTake) |=> !isrQ[$past(isrIdx)]);

  assert_eoi_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.eoiClear && !isrFound && !strobes.ackTake) |=> $stable(isrQ));

endmodule

// File: rtl/intr_prio_ctrl.sv
module intr_prio_ctrl
  import intr_prio_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int CLASS_W  = 4,
  parameter int SVR_IN_W = 16,
  localparam int CLS_LSB = VEC_W - CLASS_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqLevel,
  input  logic                ackStrobe,
  input  logic                eoiStrobe,
  input  logic                tprWrEn,
  input  logic [VEC_W-1:0]    tprWrData,
  input  logic                svrWrEn,
  input  logic [SVR_IN_W-1:0] svrWrData,
  input  logic                irrFound,
  input  logic [VEC_W-1:0]    irrIdx,
  input  logic                isrFound,
  input  logic [VEC_W-1:0]    isrIdx,
  output ctrlStrobes_t        strobes,
  output logic                intOut,
  output logic [VEC_W-1:0]    ackVector,
  output logic [VEC_W-1:0]    tprOut,
  output logic [VEC_W:0]      svrOut,
  output logic [VEC_W-1:0]    pprOut
);

  logic [VEC_W-1:0] tprQ;
  logic [VEC_W:0]   svrQ;
  logic [VEC_W-1:0] isrTop;
  logic [VEC_W-1:0] ppr;
  logic             swEnable;
  logic             ackOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tprQ <= '0;
      svrQ <= {1'b0, {VEC_W{1'b1}}};
    end else begin
      if (tprWrEn) tprQ <= tprWrData;
      if (svrWrEn) svrQ <= svrWrData[VEC_W:0];
    end
  end

  assign swEnable = svrQ[VEC_W];
  assign isrTop   = isrFound ? isrIdx : '0;

  always_comb begin
    if (tprQ[VEC_W-1:CLS_LSB] >= isrTop[VEC_W-1:CLS_LSB]) ppr = tprQ;
    else ppr = {isrTop[VEC_W-1:CLS_LSB], {CLS_LSB{1'b0}}};
  end

  always_comb begin
    intOut = swEnable && irrFound;
    if ((ppr != '0) && (irrIdx[VEC_W-1:CLS_LSB] <= ppr[VEC_W-1:CLS_LSB])) intOut = 1'b0;
  end

  always_comb begin
    ackOk = swEnable && irrFound;
    if ((tprQ != '0) && (irrIdx <= tprQ)) ackOk = 1'b0;
  end

  assign ackVector = ackOk ? irrIdx : svrQ[VEC_W-1:0];

  always_comb begin
    strobes.reqSet   = reqValid;
    strobes.reqLevel = reqLevel;
    strobes.ackTake  = ackStrobe && ackOk;
    strobes.eoiClear = eoiStrobe;
  end

  assign tprOut = tprQ;
  assign svrOut = svrQ;
  assign pprOut = ppr;

  assert_svr_keep_R9: assert property (@(posedge clk) disable iff (!rstN)
    svrWrEn |=> svrQ == $past(svrWrData[VEC_W:0]));

  assert_int_needs_enable_R4: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> (svrQ[VEC_W] && irrFound));

  assert_ppr_class_R3: assert property (@(posedge clk) disable iff (!rstN)
    (isrFound && (isrIdx[VEC_W-1:CLS_LSB] > tprQ[VEC_W-1:CLS_LSB])) |-> (pprOut[CLS_LSB-1:0] == '0));

  assert_ppr_floor_R3: assert property (@(posedge clk) disable iff (!rstN)
    pprOut >= tprQ);

  assert_refuse_spurious_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && !swEnable) |-> (ackVector == svrQ[VEC_W-1:0] && !strobes.ackTake));

endmodule

// File: rtl/intr_prio_unit.sv
module intr_prio_unit
  import intr_prio_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int CLASS_W  = 4,
  parameter int SVR_IN_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [VEC_W-1:0]    reqVector,
  input  logic                reqLevel,
  input  logic                ackStrobe,
  output logic [VEC_W-1:0]    ackVector,
  input  logic                eoiStrobe,
  input  logic                tprWrEn,
  input  logic [VEC_W-1:0]    tprWrData,
  input  logic                svrWrEn,
  input  logic [SVR_IN_W-1:0] svrWrData,
  input  logic [VEC_W-1:0]    queryVector,
  output logic                queryPending,
  output logic                queryInService,
  output logic                queryLevel,
  output logic                intOut,
  output logic [VEC_W-1:0]    pprOut,
  output logic [VEC_W-1:0]    tprOut,
  output logic [VEC_W:0]      svrOut
);

  ctrlStrobes_t     strobes;
  logic             irrFound, isrFound;
  logic [VEC_W-1:0] irrIdx, isrIdx;

  intr_prio_ctrl #(.VEC_W(VEC_W), .CLASS_W(CLASS_W), .SVR_IN_W(SVR_IN_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqLevel(reqLevel),
    .ackStrobe(ackStrobe), .eoiStrobe(eoiStrobe),
    .tprWrEn(tprWrEn), .tprWrData(tprWrData),
    .svrWrEn(svrWrEn), .svrWrData(svrWrData),
    .irrFound(irrFound), .irrIdx(irrIdx),
    .isrFound(isrFound), .isrIdx(isrIdx),
    .strobes(strobes), .intOut(intOut), .ackVector(ackVector),
    .tprOut(tprOut), .svrOut(svrOut), .pprOut(pprOut)
  );

  intr_vec_dp #(.VEC_W(VEC_W)) uDp (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .reqVector(reqVector), .queryVector(queryVector),
    .irrFound(irrFound), .irrIdx(irrIdx),
    .isrFound(isrFound), .isrIdx(isrIdx),
    .queryPending(queryPending), .queryInService(queryInService),
    .queryLevel(queryLevel)
  );

endmodule

// File: tb/tb_intr_prio_unit.sv
module tb_intr_prio_unit;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [7:0] reqVector = '0;
  logic reqLevel = 1'b0;
  logic ackStrobe = 1'b0;
  logic [7:0] ackVector;
  logic eoiStrobe = 1'b0;
  logic tprWrEn = 1'b0;
  logic [7:0] tprWrData = '0;
  logic svrWrEn = 1'b0;
  logic [15:0] svrWrData = '0;
  logic [7:0] queryVector = '0;
  logic queryPending, queryInService, queryLevel, intOut;
  logic [7:0] pprOut, tprOut;
  logic [8:0] svrOut;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  intr_prio_unit dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVector(reqVector),
    .reqLevel(reqLevel), .ackStrobe(ackStrobe), .ackVector(ackVector),
    .eoiStrobe(eoiStrobe), .tprWrEn(tprWrEn), .tprWrData(tprWrData),
    .svrWrEn(svrWrEn), .svrWrData(svrWrData), .queryVector(queryVector),
    .queryPending(queryPending), .queryInService(queryInService),
    .queryLevel(queryLevel), .intOut(intOut), .pprOut(pprOut),
    .tprOut(tprOut), .svrOut(svrOut)
  );

  task automatic chk(input string req, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic doReq(input logic [7:0] v, input logic lvl);
    @(negedge clk);
    reqValid = 1'b1; reqVector = v; reqLevel = lvl;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doAck(output logic [7:0] got);
    @(negedge clk);
    ackStrobe = 1'b1;
    #1 got = ackVector;
    @(negedge clk);
    ackStrobe = 1'b0;
  endtask

  task automatic doEoi();
    @(negedge clk);
    eoiStrobe = 1'b1;
    @(negedge clk);
    eoiStrobe = 1'b0;
  endtask

  task automatic setTpr(input logic [7:0] t);
    @(negedge clk);
    tprWrEn = 1'b1; tprWrData = t;
    @(negedge clk);
    tprWrEn = 1'b0;
  endtask

  task automatic setSvr(input logic [15:0] s);
    @(negedge clk);
    svrWrEn = 1'b1; svrWrData = s;
    @(negedge clk);
    svrWrEn = 1'b0;
  endtask

  task automatic look(input logic [7:0] v);
    queryVector = v;
    #1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  initial begin
    #(8 * 190000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R8 reset state
    chk("R8 svr", svrOut, 9'h0FF);
    chk("R8 tpr", tprOut, 0);
    chk("R8 ppr", pprOut, 0);
    chk("R8 int", intOut, 0);
    for (int v = 0; v < 256; v += 51) begin
      look(v[7:0]);
      chk("R8 maps", {queryPending, queryInService, queryLevel}, 0);
    end

    // R4/R5 disabled: pending but no interrupt, acknowledge spurious
    doReq(8'h90, 1'b0);
    #1 chk("R4 disabled int", intOut, 0);
    doAck(got);
    chk("R5 disabled ack", got, 8'hFF);
    look(8'h90);
    chk("R5 disabled unchanged", {queryPending, queryInService}, 2'b10);

    // R9 register writes
    setSvr(16'hFFA5);
    chk("R9 svr bits", svrOut, 9'h1A5);
    setTpr(8'hC7);
    chk("R9 tpr bits", tprOut, 8'hC7);
    setTpr(8'h00);
    doAck(got);
    chk("R6 ack 0x90", got, 8'h90);
    doEoi();

    // R1/R2/R5/R6 sweep over all vectors and several task priorities
    for (int ti = 0; ti < 4; ti++) begin
      logic [7:0] t;
      t = (ti == 0) ? 8'h00 : (ti == 1) ? 8'h40 : (ti == 2) ? 8'h7F : 8'hFE;
      setTpr(t);
      for (int v = 0; v < 256; v++) begin
        logic ok;
        ok = (t == 0) || (v > t);
        doReq(v[7:0], v[0]);
        look(v[7:0]);
        chk("R2 pending/level", {queryPending, queryLevel}, {1'b1, v[0]});
        doAck(got);
        chk("R1 R5 ack vector", got, ok ? v : 8'hA5);
        look(v[7:0]);
        chk("R6 R5 map move", {queryPending, queryInService}, ok ? 2'b01 : 2'b10);
        if (!ok) begin
          setTpr(8'h00);
          doAck(got);
          setTpr(t);
        end
        doEoi();
        look(v[7:0]);
        chk("R7 retired", queryInService, 0);
      end
    end
    setTpr(8'h00);

    // R1/R7 pairs: descending acknowledge and end-of-interrupt order
    for (int a = 0; a < 128; a += 7) begin
      int b, hi, lo;
      b = 255 - a; hi = b; lo = a;
      doReq(a[7:0], 1'b0);
      doReq(b[7:0], 1'b1);
      doAck(got);
      chk("R1 first ack highest", got, hi);
      doAck(got);
      chk("R1 second ack lower", got, lo);
      doEoi();
      look(hi[7:0]);
      chk("R7 eoi highest", queryInService, 0);
      look(lo[7:0]);
      chk("R7 lower kept", queryInService, 1);
      doEoi();
      chk("R7 lower retired", queryInService, 0);
    end

    // R7 end-of-interrupt with nothing in service
    doReq(8'h33, 1'b1);
    doEoi();
    look(8'h33);
    chk("R7 empty eoi no effect", {queryPending, queryInService, queryLevel}, 3'b101);
    doAck(got);
    doEoi();

    // R3/R4 sweep: in-service class vs task class vs pending class
    for (int c = 0; c < 16; c++) begin
      for (int t = 0; t < 16; t++) begin
        int isrV, tprV, pprExp, q, pv, expInt;
        isrV = c * 16 + 9;
        tprV = t * 16 + 3;
        q = (c + t) % 16;
        pv = q * 16 + 1;
        doReq(isrV[7:0], 1'b0);
        doAck(got);
        setTpr(tprV[7:0]);
        pprExp = (t >= c) ? tprV : c * 16;
        #1 chk("R3 ppr", pprOut, pprExp);
        chk("R4 idle int", intOut, 0);
        doReq(pv[7:0], 1'b0);
        expInt = ((pprExp == 0) || (q > (pprExp >> 4))) ? 1 : 0;
        #1 chk("R4 int class", intOut, expInt);
        setTpr(8'h00);
        doEoi();
        doAck(got);
        doEoi();
      end
    end

    // R10 request and acknowledge of the same vector in one cycle
    doReq(8'h6C, 1'b0);
    @(negedge clk);
    ackStrobe = 1'b1; reqValid = 1'b1; reqVector = 8'h6C; reqLevel = 1'b1;
    #1 chk("R10 ack returns", ackVector, 8'h6C);
    @(negedge clk);
    ackStrobe = 1'b0; reqValid = 1'b0;
    look(8'h6C);
    chk("R10 pending and in service", {queryPending, queryInService, queryLevel}, 3'b111);
    doAck(got);
    doEoi();
    doEoi();

    // R10 acknowledge and end-of-interrupt in one cycle
    doReq(8'h21, 1'b0);
    doAck(got);
    doReq(8'hD4, 1'b0);
    @(negedge clk);
    ackStrobe = 1'b1; eoiStrobe = 1'b1;
    @(negedge clk);
    ackStrobe = 1'b0; eoiStrobe = 1'b0;
    look(8'h21);
    chk("R10 old retired", queryInService, 0);
    look(8'hD4);
    chk("R10 new in service", {queryPending, queryInService}, 2'b01);

    summary();
    $finish;
  end

endmodule